// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller collects interrupt lines from peripherals and decides which handler a processor core should run next. Each source keeps one pending flag and one active flag. The two flags are independent, so a source can be waiting to run again while its handler is still running. Sources are ranked by a programmable priority. A more urgent source can interrupt a less urgent handler that is already running, so handlers nest. The core is modelled by two strobes: one accepts the offered vector (entry) and one retires the innermost handler (exit).

The core side follows a valid/ready pattern:

- `irq_req` is valid and `irq_ack` is ready. A handler is entered on every cycle where both are high.
- Until it is accepted, the offer is not held. The vector can switch to a more urgent source, and the request can fall when the global mask is raised or the pending flag is cleared.
- The core never has to stall the controller.
- When a handler exits and another enabled pending source outranks whatever that exit uncovers, `tail_chain` is raised in the exit cycle. The core then enters the new vector directly, without returning to the preempted level.

Each source is configured as level-sensitive or pulse-sensitive. Software-style write ports let the user program:

- a whole enable vector,
- per-source strobes that set or clear the pending flag,
- an 8-bit priority for each source. Only its upper four bits are kept.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source has a single pending flag. Any number of pulses that arrive while it is already pending lead to exactly one handler entry.
- R2: A priority write keeps only bits [7:4] of the 8-bit value, so two values with equal upper nibbles (for example 0x20 and 0x25) rank equally. A smaller value is more urgent.
- R3: The current execution level is the most urgent level among active sources, or none when no source is active. A request is raised only when the best enabled pending source is strictly more urgent than that level. An equal or less urgent source never preempts, and nesting makes several sources active at once.
- R4: On the accepting cycle (`irq_req` and `irq_ack` both high), the offered source leaves pending and becomes active at the same clock edge. `irq_done` makes the innermost active source (the most urgent one) inactive.
- R5: A level source is not re-pended while its own handler is active. If its line is still high when the handler exits, it becomes pending on the next clock edge after the exit and is requested again.
- R6: For a pulse source, a rising edge on its line sets pending even while its own handler is active. The source is then requested again after that handler exits.
- R7: While `global_mask` is 1, `irq_req` and `tail_chain` stay 0 but events still latch. After unmasking, sources are taken most urgent first, then the others in priority order.
- R8: A source whose enable bit is 0 is never requested. Its pending flag is kept and becomes visible once it is enabled.
- R9: A pulse on `pend_set[i]` makes source i pending, and a pulse on `pend_clr[i]` clears it. A cleared level source whose line is still high stays pending.
- R10: `tail_chain` is 1 in an exit cycle exactly when the mask is clear and the best enabled pending source (as it stands in that cycle) is strictly more urgent than the level left once the innermost handler is removed. The new vector is on `irq_vec` in that same cycle.
- R11: Among enabled pending sources of equal level, the lowest index is offered.
- R12: After reset, no source is pending, active or enabled, every priority level is 0, and `irq_req` and `tail_chain` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line | input | NSRC | Interrupt lines from the peripherals |
| src_level | input | NSRC | Per-source kind: 1 means level-sensitive, 0 means rising-edge pulse |
| en_we | input | 1 | Write strobe for the enable vector |
| en_wdata | input | NSRC | New enable vector, one bit per source |
| pend_set | input | NSRC | Per-source strobes that set the pending flag |
| pend_clr | input | NSRC | Per-source strobes that clear the pending flag |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | IDX_W | Source index addressed by a priority write |
| prio_wdata | input | PRIO_W | Priority value; smaller is more urgent, only the top LVL_W bits are kept |
| global_mask | input | 1 | 1 holds off all requests and tail chains |
| irq_ack | input | 1 | Core entry strobe (ready for the offered vector) |
| irq_done | input | 1 | Core exit strobe for the innermost handler |
| irq_req | output | 1 | Request to the core (valid) |
| irq_vec | output | IDX_W | Source index offered to the core |
| tail_chain | output | 1 | High in an exit cycle that chains straight into `irq_vec` |

## Verification
The assertions take three things for granted about the core:

- It raises `irq_done` only while at least one handler is active.
- It never raises `irq_done` in the same cycle as an accepted entry.
- It raises `irq_ack` only while `irq_req` is high.

The stimulus keeps to these rules by tracking the nesting depth itself. It pulses entry only after checking the request, and it issues one exit per entry. Line edges, software strobes and register writes are driven between clock edges, so pulses and writes always span at least one full cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned DEF_NSRC   = 32;
  localparam int unsigned DEF_PRIO_W = 8;
  localparam int unsigned DEF_LVL_W  = 4;
endpackage

// File: rtl/prio_irq_cell.sv
module prio_irq_cell #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             is_level,
  input  logic             en_we,
  input  logic             en_bit,
  input  logic             sw_set,
  input  logic             sw_clr,
  input  logic             take,
  input  logic             retire,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  output logic             pending,
  output logic             active,
  output logic             enabled,
  output logic [LVL_W-1:0] level
);
  logic line_q;
  logic hw_set;

  // level lines re-pend only once the own handler has left (and not while being taken)
  always_comb begin
    if (is_level) hw_set = line && !active && !take;
    else          hw_set = line && !line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      active  <= 1'b0;
      enabled <= 1'b0;
      level   <= '0;
      line_q  <= 1'b0;
    end else begin
      line_q  <= line;
      pending <= (pending && !sw_clr && !take) || sw_set || hw_set;
      active  <= (active && !retire) || take;
      if (en_we)  enabled <= en_bit;
      if (lvl_we) level   <= lvl_wdata;
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int unsigned N     = 32,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]       cand,
  input  logic [N*LVL_W-1:0] lvls,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [LVL_W-1:0]   lvl
);
  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || lvls[i*LVL_W +: LVL_W] < lvl)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        lvl   = lvls[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NSRC   = DEF_NSRC,
  parameter int unsigned PRIO_W = DEF_PRIO_W,
  parameter int unsigned LVL_W  = DEF_LVL_W,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_line,
  input  logic [NSRC-1:0]   src_level,
  input  logic              en_we,
  input  logic [NSRC-1:0]   en_wdata,
  input  logic [NSRC-1:0]   pend_set,
  input  logic [NSRC-1:0]   pend_clr,
  input  logic              prio_we,
  input  logic [IDX_W-1:0]  prio_idx,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              global_mask,
  input  logic              irq_ack,
  input  logic              irq_done,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_vec,
  output logic              tail_chain
);
  logic [NSRC-1:0]       pend_v, act_v, en_v;
  logic [NSRC-1:0]       take_oh, retire_oh, inner_oh;
  logic [NSRC*LVL_W-1:0] lvl_v;
  logic [LVL_W-1:0]      lvl_wr;
  logic                  unused_low_bits;

  logic                  p_found, a_found, r_found;
  logic [IDX_W-1:0]      p_idx, a_idx, r_idx;
  logic [LVL_W-1:0]      p_lvl, a_lvl, r_lvl;
  logic                  beats, take;

  assign lvl_wr          = prio_wdata[PRIO_W-1 -: LVL_W];
  assign unused_low_bits = ^prio_wdata[PRIO_W-LVL_W-1:0];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    prio_irq_cell #(.LVL_W(LVL_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .line      (src_line[g]),
      .is_level  (src_level[g]),
      .en_we     (en_we),
      .en_bit    (en_wdata[g]),
      .sw_set    (pend_set[g]),
      .sw_clr    (pend_clr[g]),
      .take      (take_oh[g]),
      .retire    (retire_oh[g]),
      .lvl_we    (prio_we && (prio_idx == IDX_W'(g))),
      .lvl_wdata (lvl_wr),
      .pending   (pend_v[g]),
      .active    (act_v[g]),
      .enabled   (en_v[g]),
      .level     (lvl_v[g*LVL_W +: LVL_W])
    );
  end

  // best enabled pending source
  prio_irq_arb #(.N(NSRC), .LVL_W(LVL_W)) u_arb_pend (
    .cand (pend_v & en_v), .lvls (lvl_v),
    .found(p_found), .idx(p_idx), .lvl(p_lvl)
  );

  // execution level: innermost active handler
  prio_irq_arb #(.N(NSRC), .LVL_W(LVL_W)) u_arb_act (
    .cand (act_v), .lvls (lvl_v),
    .found(a_found), .idx(a_idx), .lvl(a_lvl)
  );

  assign inner_oh = a_found ? (NSRC'(1) << a_idx) : '0;

  // level that an exit would uncover
  prio_irq_arb #(.N(NSRC), .LVL_W(LVL_W)) u_arb_rest (
    .cand (act_v & ~inner_oh), .lvls (lvl_v),
    .found(r_found), .idx(r_idx), .lvl(r_lvl)
  );

  assign beats      = p_found && (!a_found || (p_lvl < a_lvl));
  assign irq_req    = beats && !global_mask;
  assign irq_vec    = p_idx;
  assign take       = irq_req && irq_ack;
  assign take_oh    = take ? (NSRC'(1) << p_idx) : '0;
  assign retire_oh  = irq_done ? inner_oh : '0;
  assign tail_chain = irq_done && a_found && !global_mask && p_found &&
                      (!r_found || (p_lvl < r_lvl));

  logic unused_r_idx;
  assign unused_r_idx = ^r_idx;

  assert_take_activates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> act_v[$past(irq_vec)]);

  assert_only_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_v[irq_vec] && pend_v[irq_vec]));

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    global_mask |-> (!irq_req && !tail_chain));

  assert_nest_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && !irq_done) |=>
      ($countones(act_v) == $past($countones(act_v)) + 1));

  assert_retire_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !irq_ack && (act_v != '0)) |=>
      ($countones(act_v) + 1 == $past($countones(act_v))));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  localparam int N = 8;
  localparam int IW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_line = '0;
  logic [N-1:0] src_level = 8'b0010_0100;
  logic en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic [N-1:0] pend_set = '0, pend_clr = '0;
  logic prio_we = 1'b0;
  logic [IW-1:0] prio_idx = '0;
  logic [7:0] prio_wdata = '0;
  logic global_mask = 1'b0;
  logic irq_ack = 1'b0, irq_done = 1'b0;
  logic irq_req, tail_chain;
  logic [IW-1:0] irq_vec;

  int n_checks = 0, n_fail = 0;
  int cyc_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NSRC(N), .PRIO_W(8), .LVL_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_line(src_line), .src_level(src_level),
    .en_we(en_we), .en_wdata(en_wdata), .pend_set(pend_set), .pend_clr(pend_clr),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
    .global_mask(global_mask), .irq_ack(irq_ack), .irq_done(irq_done),
    .irq_req(irq_req), .irq_vec(irq_vec), .tail_chain(tail_chain)
  );

  // ---------------- behavioural reference model ----------------
  bit m_pend[N], m_act[N], m_en[N], m_prev[N];
  int m_lvl[N];

  function automatic int best_pend(output int lv);
    int b = -1;
    lv = 99;
    foreach (m_pend[i]) if (m_pend[i] && m_en[i] && m_lvl[i] < lv) begin b = i; lv = m_lvl[i]; end
    return b;
  endfunction

  function automatic int best_act(input int excl, output int lv);
    int b = -1;
    lv = 99;
    foreach (m_act[i]) if (m_act[i] && i != excl && m_lvl[i] < lv) begin b = i; lv = m_lvl[i]; end
    return b;
  endfunction

  function automatic bit exp_req();
    int pl, al, p, a;
    p = best_pend(pl);
    a = best_act(-1, al);
    return (p >= 0) && (a < 0 || pl < al) && !global_mask;
  endfunction

  function automatic bit exp_tail();
    int pl, al, rl, p, a, r;
    p = best_pend(pl);
    a = best_act(-1, al);
    r = best_act(a, rl);
    return irq_done && (a >= 0) && !global_mask && (p >= 0) && (r < 0 || pl < rl);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_act[i] = 0; m_en[i] = 0; m_prev[i] = 0; m_lvl[i] = 0; end
    end else begin
      int pl, al, p, a;
      bit tk;
      bit hw;
      p  = best_pend(pl);
      a  = best_act(-1, al);
      tk = exp_req() && irq_ack;
      foreach (m_pend[i]) begin
        if (src_level[i]) hw = src_line[i] && !m_act[i] && !(tk && p == i);
        else              hw = src_line[i] && !m_prev[i];
        m_pend[i] = (m_pend[i] && !pend_clr[i] && !(tk && p == i)) || pend_set[i] || hw;
        m_act[i]  = (m_act[i] && !(irq_done && a == i)) || (tk && p == i);
        m_prev[i] = src_line[i];
        if (en_we) m_en[i] = en_wdata[i];
      end
      if (prio_we) m_lvl[prio_idx] = int'(prio_wdata) / 16;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int pl, p;
      check("R3 irq_req vs model", int'(irq_req), int'(exp_req()));
      check("R10 tail_chain vs model", int'(tail_chain), int'(exp_tail()));
      if (exp_req()) begin
        p = best_pend(pl);
        check("R11 irq_vec vs model", int'(irq_vec), p);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic mid(); @(negedge clk); endtask

  task automatic pulse(input int s);
    cyc(); src_line[s] = 1'b1;
    cyc(); src_line[s] = 1'b0;
  endtask

  task automatic take_it();
    cyc(); irq_ack = 1'b1;
    cyc(); irq_ack = 1'b0;
  endtask

  task automatic retire(input int exp_t, input string tag);
    cyc(); irq_done = 1'b1;
    mid(); check(tag, int'(tail_chain), exp_t);
    cyc(); irq_done = 1'b0;
  endtask

  task automatic wr_prio(input int idx, input int val);
    cyc(); prio_we = 1'b1; prio_idx = IW'(idx); prio_wdata = 8'(val);
    cyc(); prio_we = 1'b0;
  endtask

  task automatic wr_en(input logic [N-1:0] v);
    cyc(); en_we = 1'b1; en_wdata = v;
    cyc(); en_we = 1'b0;
  endtask

  task automatic req_is(input string tag, input int r, input int v);
    mid();
    check(tag, int'(irq_req), r);
    if (r == 1) check(tag, int'(irq_vec), v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mid(); check("R12 reset irq_req", int'(irq_req), 0);
    check("R12 reset tail_chain", int'(tail_chain), 0);

    // R8: pending latched while disabled, visible once enabled
    pulse(1); cyc(); req_is("R8 disabled src not requested", 0, 0);
    wr_prio(0, 8'h40); wr_prio(1, 8'h80); wr_prio(2, 8'h30); wr_prio(3, 8'h20);
    wr_prio(4, 8'h25); wr_prio(5, 8'h60); wr_prio(6, 8'h10); wr_prio(7, 8'hF0);
    wr_en(8'h02); req_is("R8 latched pending after enable", 1, 1);
    take_it(); req_is("R4 pending cleared on entry", 0, 0);
    retire(0, "R10 no chain with nothing pending");
    wr_en(8'hFF);

    // R1: merged pulses under mask
    cyc(); global_mask = 1'b1;
    pulse(0); pulse(0); pulse(0);
    cyc(); global_mask = 1'b0;
    req_is("R1 merged pulses request src0", 1, 0);
    take_it(); req_is("R1 only one entry for merged pulses", 0, 0);
    retire(0, "R1 no chain after merged entry");

    // R7: masked latching, priority order after unmask
    cyc(); global_mask = 1'b1;
    pulse(7); pulse(0); pulse(6);
    req_is("R7 masked no request", 0, 0);
    cyc(); global_mask = 1'b0;
    req_is("R7 most urgent first", 1, 6);
    take_it(); req_is("R3 less urgent does not preempt", 0, 0);
    retire(1, "R10 chain from 6 to 0");
    req_is("R7 second in order", 1, 0);
    take_it(); retire(1, "R10 chain from 0 to 7");
    req_is("R7 third in order", 1, 7);
    take_it(); retire(0, "R10 no chain after last");
    req_is("R7 all served", 0, 0);

    // R2 / R11: equal nibble, lowest index wins
    cyc(); global_mask = 1'b1;
    pulse(4); pulse(3);
    cyc(); global_mask = 1'b0;
    req_is("R11 tie lowest index", 1, 3);
    take_it(); req_is("R2 0x25 equals 0x20, no preempt", 0, 0);
    retire(1, "R10 chain to equal-level src4");
    req_is("R2 src4 offered after exit", 1, 4);
    take_it(); retire(0, "R10 no chain after src4");

    // R3: nesting with strict preemption
    pulse(0); req_is("R3 src0 requested", 1, 0);
    take_it();
    pulse(6); req_is("R3 more urgent preempts", 1, 6);
    take_it();
    pulse(7); req_is("R3 worse source waits while nested", 0, 0);
    retire(0, "R10 no chain to worse than uncovered level");
    req_is("R3 src7 still below src0", 0, 0);
    retire(1, "R10 chain to src7 on final exit");
    req_is("R3 src7 offered", 1, 7);
    take_it(); retire(0, "R10 no chain after src7");

    // R5: level source re-pends after exit
    cyc(); src_line[2] = 1'b1;
    cyc(); req_is("R5 level source requested", 1, 2);
    take_it(); req_is("R5 no re-pend while active", 0, 0);
    retire(0, "R5 no chain in exit cycle");
    req_is("R5 not yet pending at exit edge", 0, 0);
    cyc(); req_is("R5 re-pended after exit", 1, 2);
    take_it(); src_line[2] = 1'b0;
    retire(0, "R5 no chain after line dropped");
    cyc(); req_is("R5 settled", 0, 0);

    // R6: pulse during own handler
    pulse(1); take_it();
    pulse(1); req_is("R6 own repend does not preempt", 0, 0);
    retire(1, "R6 chain back into src1");
    req_is("R6 src1 again", 1, 1);
    take_it(); retire(0, "R6 no chain after rerun");

    // R9: software set/clear
    cyc(); pend_set[0] = 1'b1;
    cyc(); pend_set[0] = 1'b0;
    req_is("R9 sw set", 1, 0);
    cyc(); pend_clr[0] = 1'b1;
    cyc(); pend_clr[0] = 1'b0;
    req_is("R9 sw clear", 0, 0);
    cyc(); src_line[5] = 1'b1;
    cyc(); req_is("R9 level src5 pending", 1, 5);
    cyc(); pend_clr[5] = 1'b1;
    cyc(); pend_clr[5] = 1'b0;
    req_is("R9 cleared level re-pends", 1, 5);
    src_line[5] = 1'b0;
    take_it(); retire(0, "R9 no chain after src5");

    // R8: disabled source with pending flag
    wr_en(8'hBF);
    pulse(6); cyc(); req_is("R8 disabled src6 ignored", 0, 0);
    wr_en(8'hFF); req_is("R8 src6 after re-enable", 1, 6);
    take_it(); retire(0, "R8 no chain after src6");
    cyc(); req_is("R4 idle at end", 0, 0);

    repeat (3) cyc();
    finish_run();
  end
endmodule